// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test access point of a chip. A sixteen-state controller advances on every rising edge of the test clock. The only thing that decides its path is the level of the mode-select input. The path leads either through the instruction scan branch or through the data scan branch.

Each branch captures a value, shifts it serially from the data input towards the data output, and then commits it. An instruction register picks which data register sits in the serial path. There are three data registers:
- a 32-bit identification register;
- a one-bit bypass stage;
- a boundary register whose parallel inputs come from the device pins and whose outputs go through update latches.

The serial output and the update latches change on the falling clock edge. Parallel outputs therefore never ripple while data is shifting. Reset and the run of mode-select highs both leave the identification instruction active.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the controller enters Test-Logic-Reset. After that edge and the following falling edge, `in_reset`=1, `ir_out`=4'b0001, `tdo_en`=0, `tdo`=0 and `bsr_out`=0.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. At the next falling edge `ir_out` returns to 4'b0001.
- R3: State changes happen only on rising edges and follow the standard sixteen-state graph under `tms`. `in_reset` is high exactly while the controller is in Test-Logic-Reset.
- R4: Capture-IR loads 4'b0001 into the instruction shift stage, so its two low bits are 01. Shift-IR moves it towards `tdo`, LSB first, with `tdi` entering the MSB. `ir_out` changes only on the falling edge in Update-IR or in Test-Logic-Reset.
- R5: Opcode 4'b0001 selects the identification register. Capture-DR loads `ID_VALUE` into it, and the value shifts out LSB first.
- R6: Opcode 4'b1111, and every opcode that has no other meaning, selects a one-bit bypass stage. That stage captures 0 and delays `tdi` by one shift.
- R7: Opcodes 4'b0000 (external test) and 4'b0010 (sample/preload) select the boundary register. Capture-DR loads `pin_in` in parallel. Bit 0 is nearest `tdo`, and `tdi` enters the top bit.
- R8: `bsr_out` is loaded from the boundary register only on the falling edge in Update-DR while the boundary register is selected. At all other times it holds, including while shifting and while other instructions are active.
- R9: `tdo` and `tdo_en` change on the falling edge. `tdo_en` is high only in Shift-DR and Shift-IR, and `tdo` is 0 while `tdo_en` is low.
- R10: `extest_on` is high exactly while `ir_out` holds the external-test opcode 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising edges |
| tdi | input | 1 | Serial test data in |
| pin_in | input | BSR_W | Pin values captured by the boundary register |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for `tdo` (tri-state control) |
| ir_out | output | 4 | Active instruction |
| in_reset | output | 1 | High in Test-Logic-Reset |
| extest_on | output | 1 | External-test instruction active |
| bsr_out | output | BSR_W | Boundary update latches |

## Verification
The hardest cases to reach from the ports are the five-high escape from deep states such as Pause-IR or Exit2-DR, and update latches that must hold when a data scan runs under a non-boundary instruction. The stimulus loads instructions drawn at random, including unassigned opcodes. It then runs data scans of random length and free walks of the mode-select input biased towards low. These walks settle into the pause and exit loops, and a bench model of the registers predicts every output at each falling edge. Directed scans pin down the capture pattern, the identification word, the bypass delay and the boundary capture and update.

// File: rtl/scan_pkg.sv
// Shared definitions for the test access port: controller states,
// instruction codes, data register selection and the transition function.
package scan_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {SEL_BSR, SEL_ID, SEL_BYP} dr_sel_e;

    // Next controller state for the current state and mode-select level.
    function automatic tap_state_e tap_next(tap_state_e cur, logic m);
        tap_state_e nxt;
        case (cur)
            ST_TLR:    nxt = m ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = m ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = m ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = m ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
// Sixteen-state controller. Advances on the rising test clock edge from
// the mode-select level alone and decodes per-state strobes for the
// instruction and data register paths.
// Assumes: rst_n is synchronous to tck.
module scan_fsm
    import scan_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic tms,
    output logic cap_dr,
    output logic sh_dr,
    output logic upd_dr,
    output logic cap_ir,
    output logic sh_ir,
    output logic upd_ir,
    output logic tlr
);

    tap_state_e state_q;
    logic [2:0] hi_run_q;

    // State register: reset forces Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state_q <= ST_TLR;
        else        state_q <= tap_next(state_q, tms);
    end

    // Strobe decode for the register paths.
    always_comb begin
        cap_dr = (state_q == ST_CAP_DR);
        sh_dr  = (state_q == ST_SH_DR);
        upd_dr = (state_q == ST_UPD_DR);
        cap_ir = (state_q == ST_CAP_IR);
        sh_ir  = (state_q == ST_SH_IR);
        upd_ir = (state_q == ST_UPD_IR);
        tlr    = (state_q == ST_TLR);
    end

    // Run length of consecutive mode-select highs, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n)         hi_run_q <= '0;
        else if (!tms)      hi_run_q <= '0;
        else if (hi_run_q != 3'd5) hi_run_q <= hi_run_q + 3'd1;
    end

    AST_FIVE_HIGH_RESET: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_run_q == 3'd5) |-> (state_q == ST_TLR)); // R2
    AST_CAPTURE_TO_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_CAP_DR && !tms) |=> (state_q == ST_SH_DR)); // R3
    AST_SELECT_IR_ESCAPE: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_SEL_IR && tms) |=> (state_q == ST_TLR)); // R3

endmodule

// File: rtl/scan_ir.sv
// Instruction register: a shift stage clocked on the rising edge and an
// active-instruction latch loaded on the falling edge in Update-IR.
// Assumes: strobes come from scan_fsm in the same clock domain.
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tlr,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    // Shift stage: fixed capture pattern, then serial shift towards tdo.
    always_ff @(posedge tck) begin
        if (!rst_n)      ir_sr <= '0;
        else if (cap_ir) ir_sr <= {{(IR_W-2){1'b0}}, 2'b01};
        else if (sh_ir)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: identification on reset, committed on Update-IR.
    always_ff @(negedge tck) begin
        if (!rst_n || tlr) ir_q <= OP_IDCODE;
        else if (upd_ir)   ir_q <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    AST_IR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        !(upd_ir || tlr) |-> $stable(ir_q)); // R4
    AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!rst_n)
        cap_ir |=> (ir_sr[1:0] == 2'b01)); // R4

endmodule

// File: rtl/scan_dr.sv
// Data registers: identification, bypass and boundary register with update
// latches. Only the register picked by the active instruction captures or
// shifts, and the boundary latches load on the falling edge in Update-DR.
// Assumes: ir_q is stable while the controller is in the data branch.
module scan_dr
    import scan_pkg::*;
#(
    parameter int              BSR_W    = 8,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h2B7D_40A3
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic [IR_W-1:0]  ir_q,
    input  logic             cap_dr,
    input  logic             sh_dr,
    input  logic             upd_dr,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pin_in,
    output logic             dr_lsb,
    output logic [BSR_W-1:0] bsr_out
);

    dr_sel_e          sel;
    logic [ID_W-1:0]  id_sr;
    logic             byp_q;
    logic [BSR_W-1:0] bsr_sr;
    logic [BSR_W-1:0] bsr_src;
    logic             bsr_on;

    // Instruction decode into the selected data register.
    always_comb begin
        case (ir_q)
            OP_EXTEST, OP_SAMPLE: sel = SEL_BSR;
            OP_IDCODE:            sel = SEL_ID;
            OP_BYPASS:            sel = SEL_BYP;
            default:              sel = SEL_BYP;
        endcase
    end

    assign bsr_on = (sel == SEL_BSR);

    // Identification register: loads the fixed code, then shifts.
    always_ff @(posedge tck) begin
        if (!rst_n)                        id_sr <= '0;
        else if (sel == SEL_ID && cap_dr)  id_sr <= ID_VALUE;
        else if (sel == SEL_ID && sh_dr)   id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Bypass stage: captures zero, then passes tdi through one stage.
    always_ff @(posedge tck) begin
        if (!rst_n)                        byp_q <= 1'b0;
        else if (sel == SEL_BYP && cap_dr) byp_q <= 1'b0;
        else if (sel == SEL_BYP && sh_dr)  byp_q <= tdi;
    end

    // Boundary cells: parallel capture from pins or serial shift.
    for (genvar i = 0; i < BSR_W; i++) begin : g_cell
        logic cell_q;
        if (i == BSR_W - 1) begin : g_top
            assign bsr_src[i] = tdi;
        end else begin : g_mid
            assign bsr_src[i] = bsr_sr[i+1];
        end
        // One boundary cell.
        always_ff @(posedge tck) begin
            if (!rst_n)                cell_q <= 1'b0;
            else if (bsr_on && cap_dr) cell_q <= pin_in[i];
            else if (bsr_on && sh_dr)  cell_q <= bsr_src[i];
        end
        assign bsr_sr[i] = cell_q;
    end

    // Update latches: falling-edge copy of the boundary shift path.
    always_ff @(negedge tck) begin
        if (!rst_n)                bsr_out <= '0;
        else if (upd_dr && bsr_on) bsr_out <= bsr_sr;
    end

    // Serial output of the selected register.
    always_comb begin
        case (sel)
            SEL_BSR: dr_lsb = bsr_sr[0];
            SEL_ID:  dr_lsb = id_sr[0];
            default: dr_lsb = byp_q;
        endcase
    end

    AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && sel == SEL_ID) |=> (id_sr == ID_VALUE)); // R5
    AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && sel == SEL_BYP) |=> !byp_q); // R6
    AST_BSR_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && bsr_on) |=> (bsr_sr == $past(pin_in))); // R7
    AST_BSR_LATCH_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        !upd_dr |-> $stable(bsr_out)); // R8

endmodule

// File: rtl/scan_tap_ctrl.sv
// Top of the test access port. Joins the controller, instruction register
// and data registers, and retimes the serial output and its enable onto
// the falling clock edge.
// Assumes: rst_n is synchronous to tck; tdo_en drives an external tri-state.
module scan_tap_ctrl
    import scan_pkg::*;
#(
    parameter int              BSR_W    = 8,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h2B7D_40A3
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pin_in,
    output logic             tdo,
    output logic             tdo_en,
    output logic [IR_W-1:0]  ir_out,
    output logic             in_reset,
    output logic             extest_on,
    output logic [BSR_W-1:0] bsr_out
);

    logic cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir, tlr;
    logic ir_lsb, dr_lsb;

    scan_fsm u_fsm (
        .tck    (tck),
        .rst_n  (rst_n),
        .tms    (tms),
        .cap_dr (cap_dr),
        .sh_dr  (sh_dr),
        .upd_dr (upd_dr),
        .cap_ir (cap_ir),
        .sh_ir  (sh_ir),
        .upd_ir (upd_ir),
        .tlr    (tlr)
    );

    scan_ir u_ir (
        .tck    (tck),
        .rst_n  (rst_n),
        .tlr    (tlr),
        .cap_ir (cap_ir),
        .sh_ir  (sh_ir),
        .upd_ir (upd_ir),
        .tdi    (tdi),
        .ir_q   (ir_out),
        .ir_lsb (ir_lsb)
    );

    scan_dr #(
        .BSR_W    (BSR_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .ir_q    (ir_out),
        .cap_dr  (cap_dr),
        .sh_dr   (sh_dr),
        .upd_dr  (upd_dr),
        .tdi     (tdi),
        .pin_in  (pin_in),
        .dr_lsb  (dr_lsb),
        .bsr_out (bsr_out)
    );

    // Serial output retimed to the falling edge, driven only while shifting.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= sh_dr || sh_ir;
            tdo    <= sh_ir ? ir_lsb : (sh_dr ? dr_lsb : 1'b0);
        end
    end

    assign in_reset  = tlr;
    assign extest_on = (ir_out == OP_EXTEST);

    AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (sh_dr || sh_ir)); // R9
    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> !tdo); // R9

endmodule

// File: tb/tb_scan_tap_ctrl.sv
module tb_scan_tap_ctrl;

    localparam int          BSR_W    = 8;
    localparam logic [31:0] ID_VALUE = 32'h2B7D_40A3;

    localparam int S_TLR = 0,  S_RTI = 1,  S_SDS = 2,  S_CDR = 3,  S_SDR = 4;
    localparam int S_E1D = 5,  S_PDR = 6,  S_E2D = 7,  S_UDR = 8,  S_SIS = 9;
    localparam int S_CIR = 10, S_SIR = 11, S_E1I = 12, S_PIR = 13, S_E2I = 14;
    localparam int S_UIR = 15;

    logic             tck = 1'b0;
    logic             rst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic [BSR_W-1:0] pin_in = '0;
    logic             tdo, tdo_en, in_reset, extest_on;
    logic [3:0]       ir_out;
    logic [BSR_W-1:0] bsr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int               ms;
    logic [3:0]       m_ir, m_irsr;
    logic [31:0]      m_id;
    logic             m_byp;
    logic [BSR_W-1:0] m_bsr, m_bout;
    logic             last_tdo;

    scan_tap_ctrl #(.BSR_W(BSR_W), .ID_VALUE(ID_VALUE)) dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .ir_out(ir_out), .in_reset(in_reset),
        .extest_on(extest_on), .bsr_out(bsr_out)
    );

    always #5 tck = ~tck;

    function automatic int nxt(int s, bit t);
        case (s)
            S_TLR: return t ? S_TLR : S_RTI;
            S_RTI: return t ? S_SDS : S_RTI;
            S_SDS: return t ? S_SIS : S_CDR;
            S_CDR: return t ? S_E1D : S_SDR;
            S_SDR: return t ? S_E1D : S_SDR;
            S_E1D: return t ? S_UDR : S_PDR;
            S_PDR: return t ? S_E2D : S_PDR;
            S_E2D: return t ? S_UDR : S_SDR;
            S_UDR: return t ? S_SDS : S_RTI;
            S_SIS: return t ? S_TLR : S_CIR;
            S_CIR: return t ? S_E1I : S_SIR;
            S_SIR: return t ? S_E1I : S_SIR;
            S_E1I: return t ? S_UIR : S_PIR;
            S_PIR: return t ? S_E2I : S_PIR;
            S_E2I: return t ? S_UIR : S_SIR;
            default: return t ? S_SDS : S_RTI;
        endcase
    endfunction

    // 0 = boundary, 1 = identification, 2 = bypass
    function automatic int msel(logic [3:0] op);
        if (op == 4'b0000 || op == 4'b0010) return 0;
        if (op == 4'b0001) return 1;
        return 2;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit t, bit d);
        logic exp_tdo;
        string tag;
        tms = t;
        tdi = d;
        @(negedge tck);
        #1;
        if (ms == S_TLR)      m_ir = 4'b0001;
        else if (ms == S_UIR) m_ir = m_irsr;
        if (ms == S_UDR && msel(m_ir) == 0) m_bout = m_bsr;
        exp_tdo = 1'b0;
        tag = "R9 tdo";
        if (ms == S_SIR) begin
            exp_tdo = m_irsr[0];
            tag = "R4 tdo";
        end else if (ms == S_SDR) begin
            case (msel(m_ir))
                0: begin exp_tdo = m_bsr[0]; tag = "R7 tdo"; end
                1: begin exp_tdo = m_id[0];  tag = "R5 tdo"; end
                default: begin exp_tdo = m_byp; tag = "R6 tdo"; end
            endcase
        end
        last_tdo = tdo;
        chk("R9 tdo_en", 64'(tdo_en), 64'(ms == S_SDR || ms == S_SIR));
        chk(tag, 64'(tdo), 64'(exp_tdo));
        chk("R4 ir_out", 64'(ir_out), 64'(m_ir));
        chk("R8 bsr_out", 64'(bsr_out), 64'(m_bout));
        chk("R3 in_reset", 64'(in_reset), 64'(ms == S_TLR));
        chk("R10 extest_on", 64'(extest_on), 64'(m_ir == 4'b0000));
        @(posedge tck);
        #1;
        case (ms)
            S_CIR: m_irsr = 4'b0001;
            S_SIR: m_irsr = {d, m_irsr[3:1]};
            S_CDR: case (msel(m_ir))
                       0: m_bsr = pin_in;
                       1: m_id  = ID_VALUE;
                       default: m_byp = 1'b0;
                   endcase
            S_SDR: case (msel(m_ir))
                       0: m_bsr = {d, m_bsr[BSR_W-1:1]};
                       1: m_id  = {d, m_id[31:1]};
                       default: m_byp = d;
                   endcase
            default: ;
        endcase
        ms = nxt(ms, t);
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // From idle: load an opcode and return the captured pattern.
    task automatic load_ir(logic [3:0] op, output logic [3:0] cap);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i]);
            cap[i] = last_tdo;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // From idle: a data scan of n bits, returning the bits seen on tdo.
    task automatic scan_dr(int n, logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = last_tdo;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0]  cap;
        logic [63:0] dout;
        logic [3:0]  op;
        void'($urandom(32'd20240611));
        ms = S_TLR; m_ir = 4'b0001; m_irsr = '0; m_id = '0;
        m_byp = 1'b0; m_bsr = '0; m_bout = '0;

        rst_n = 1'b0;
        tms = 1'b1;
        repeat (3) @(posedge tck);
        #1;
        rst_n = 1'b1;
        chk("R1 in_reset", 64'(in_reset), 64'd1);
        chk("R1 ir_out", 64'(ir_out), 64'h1);
        chk("R1 tdo_en", 64'(tdo_en), 64'd0);
        chk("R1 tdo", 64'(tdo), 64'd0);
        chk("R1 bsr_out", 64'(bsr_out), 64'd0);

        step(1'b0, 1'b0);
        // R5: identification word, LSB first
        scan_dr(32, 64'h0, dout);
        chk("R5 id word", dout[31:0], 64'(ID_VALUE));

        // R4: capture pattern seen while loading bypass
        load_ir(4'b1111, cap);
        chk("R4 capture pattern", 64'(cap), 64'h1);
        chk("R4 ir loaded", 64'(ir_out), 64'hF);
        // R6: one-stage delay with zero captured
        scan_dr(8, 64'hB2, dout);
        chk("R6 bypass delay", dout[7:0], 64'h64);

        // R6: unassigned opcode also bypasses
        load_ir(4'b0101, cap);
        scan_dr(6, 64'h2D, dout);
        chk("R6 unassigned bypass", dout[5:0], 64'h1A);

        // R7 and R8: external test capture, shift and update
        pin_in = 8'hA6;
        load_ir(4'b0000, cap);
        chk("R10 extest_on", 64'(extest_on), 64'd1);
        scan_dr(8, 64'h3C, dout);
        chk("R7 boundary capture", dout[7:0], 64'hA6);
        chk("R8 update latch", 64'(bsr_out), 64'h3C);

        // R8: a scan under the identification instruction leaves latches alone
        load_ir(4'b0001, cap);
        scan_dr(32, 64'hFFFF_FFFF, dout);
        chk("R8 latch hold", 64'(bsr_out), 64'h3C);
        chk("R10 extest_off", 64'(extest_on), 64'd0);

        // R2: escape from Pause-IR with bypass loaded
        load_ir(4'b1111, cap);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        chk("R2 reached pause", 64'(ms), 64'(S_PIR));
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk("R2 in_reset", 64'(in_reset), 64'd1);
        step(1'b1, 1'b0);
        chk("R2 ir back to id", 64'(ir_out), 64'h1);

        // Random phase: instructions, scans of random length, free walks
        for (int it = 0; it < 40; it++) begin
            to_idle();
            case ($urandom % 5)
                0: op = 4'b0000;
                1: op = 4'b0001;
                2: op = 4'b0010;
                3: op = 4'b1111;
                default: op = 4'($urandom);
            endcase
            pin_in = BSR_W'($urandom);
            load_ir(op, cap);
            scan_dr(1 + int'($urandom % 40), {$urandom, $urandom}, dout);
            for (int k = 0; k < 30; k++) begin
                pin_in = BSR_W'($urandom);
                step(($urandom % 100) < 35, 1'($urandom));
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule